// File: doc/BRIEF.md
# Operand Shifter with Carry-Out

This block forms the second operand of an integer datapath. A 32-bit source word is shifted left, shifted right logically, shifted right arithmetically, or rotated right. The shift amount comes either from a 5-bit immediate field or from an 8-bit value taken from a register. Alongside the shifted word, the block produces a carry-out. That carry-out becomes the new carry flag for logical operations. The block follows the special meanings of zero and of large amounts. An immediate amount of zero does not mean "no shift" for every kind of shift. A register amount of 32 or more saturates in a way that depends on the kind of shift.

A second mode builds a constant. An 8-bit immediate is zero-extended and rotated right by twice a 4-bit field. In this mode the carry-out is either the incoming carry or the top bit of the result.

Each operation is presented with `in_valid` and captured on the next rising clock edge. The result and the carry-out appear on registered outputs one cycle later, and they hold until the next valid operation. Reading register values is outside this block: the caller supplies the source word and the 8-bit register amount.

Top module: `opshift_unit`

## Requirements
- R1: An operation presented with `in_valid` high at a rising edge appears on `out_value`/`out_carry` with `out_valid` high after that edge. When `in_valid` is low, `out_valid` goes low and `out_value`/`out_carry` keep their previous values.
- R2: The shift kind encoding is 0 = shift left logical, 1 = shift right logical, 2 = shift right arithmetic, 3 = rotate right. For an amount n from 1 to 31, the result is the shifted word. The carry-out is the last bit moved out: source bit 32-n for a left shift, and source bit n-1 for the right shifts and the rotation.
- R3: Immediate form (`amt_from_reg` = 0), left shift with amount 0: the result is the source unchanged and the carry-out equals `carry_in`.
- R4: Immediate form, logical or arithmetic right shift with amount 0: the amount is treated as 32. The logical shift gives 0. The arithmetic shift gives 32 copies of source bit 31. The carry-out is source bit 31 in both cases.
- R5: Immediate form, rotation with amount 0: rotate right by one through carry. The result is {`carry_in`, source[31:1]} and the carry-out is source bit 0.
- R6: Register form (`amt_from_reg` = 1), amount 0, any kind: the result is the source unchanged and the carry-out equals `carry_in`.
- R7: Register form, left or logical right shift. With amount exactly 32, the result is 0 and the carry-out is source bit 0 (left shift) or source bit 31 (right shift). With an amount from 33 to 255, the result is 0 and the carry-out is 0.
- R8: Register form, arithmetic right shift with an amount from 32 to 255: the result is 32 copies of source bit 31 and the carry-out is source bit 31.
- R9: Register form, rotation. A non-zero amount whose low 5 bits are zero gives the source unchanged, with carry-out equal to source bit 31. Any other amount rotates by the amount modulo 32, as in R2.
- R10: Rotated-immediate mode (`rot_imm_mode` = 1): the result is the zero-extended `imm_byte` rotated right by 2×`imm_rot`. The carry-out is `carry_in` when `imm_rot` is 0, and result bit 31 otherwise.
- R11: In rotated-immediate mode, `src_operand`, `shift_kind`, `amt_from_reg`, `imm_amount` and `reg_amount` have no effect on the output.
- R12: While `rst` is high at a rising edge, `out_valid`, `out_value` and `out_carry` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| src_operand | input | 32 | Word to be shifted |
| shift_kind | input | 2 | 0 left, 1 logical right, 2 arithmetic right, 3 rotate |
| amt_from_reg | input | 1 | 1: use reg_amount, 0: use imm_amount |
| imm_amount | input | 5 | Immediate shift amount |
| reg_amount | input | 8 | Low byte of the amount register |
| carry_in | input | 1 | Current carry flag |
| rot_imm_mode | input | 1 | 1: build the rotated 8-bit constant instead |
| imm_byte | input | 8 | Constant byte for rotated-immediate mode |
| imm_rot | input | 4 | Half the rotation amount for rotated-immediate mode |
| out_valid | output | 1 | Registered result valid |
| out_value | output | 32 | Registered shifted value |
| out_carry | output | 1 | Registered shifter carry-out |

## Verification
Every kind of shift is swept over amounts 1 to 31 on three source words:
- one with both end bits set, which shows whether the carry comes from the correct end;
- an irregular mixed word, which catches bit misplacement;
- a positive word with bit 0 clear, which separates sign fill from zero fill.

The amount-zero immediates are run with both carry values, so a pass-through cannot be confused with an all-zero result. The register amounts 0, 31, 32, 33, 64 and 255 probe the saturation boundaries for each kind. Rotated constants are tried with rotations 0, 1, 4 and 15, and with conflicting shift fields present, which shows that the shift fields are ignored in that mode.

// File: rtl/opsh_pkg.sv
`timescale 1ns/1ps
package opsh_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_LSR = 2'd1,
    SK_ASR = 2'd2,
    SK_ROR = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/opsh_barrel.sv
`timescale 1ns/1ps
// Plain shifter for amounts 0..DATA_W-1; carry is the last bit moved out.
module opsh_barrel
  import opsh_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  shift_kind_e        kind,
  input  logic [DATA_W-1:0]  val,
  input  logic [SH_W-1:0]    amt,
  output logic [DATA_W-1:0]  res,
  output logic               cout
);
  logic [DATA_W:0]          lsl_w;
  logic [DATA_W:0]          lsr_w;
  logic signed [DATA_W:0]   asr_w;
  logic [2*DATA_W-1:0]      ror_w;

  assign lsl_w = {1'b0, val} << amt;
  assign lsr_w = {val, 1'b0} >> amt;
  assign asr_w = $signed({val, 1'b0}) >>> amt;
  assign ror_w = {val, val} >> amt;

  always_comb begin
    res  = '0;
    cout = 1'b0;
    case (kind)
      SK_LSL: begin
        res  = lsl_w[DATA_W-1:0];
        cout = lsl_w[DATA_W];
      end
      SK_LSR: begin
        res  = lsr_w[DATA_W:1];
        cout = lsr_w[0];
      end
      SK_ASR: begin
        res  = asr_w[DATA_W:1];
        cout = asr_w[0];
      end
      default: begin
        res  = ror_w[DATA_W-1:0];
        cout = ror_w[DATA_W-1];
      end
    endcase
  end
endmodule

// File: rtl/opsh_amount_decode.sv
`timescale 1ns/1ps
// Resolves zero and saturating amounts into a fixed result, or passes
// an in-range amount on to the barrel.
module opsh_amount_decode
  import opsh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RAMT_W = 8,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  shift_kind_e        kind,
  input  logic               from_reg,
  input  logic [SH_W-1:0]    imm_amt,
  input  logic [RAMT_W-1:0]  reg_amt,
  input  logic [DATA_W-1:0]  val,
  input  logic               carry_in,
  output logic [SH_W-1:0]    bar_amt,
  output logic               use_fixed,
  output logic [DATA_W-1:0]  fixed_val,
  output logic               fixed_carry
);
  localparam logic [RAMT_W:0] FULL = (RAMT_W+1)'(DATA_W);

  logic              sign;
  logic              reg_zero;
  logic              reg_eq;
  logic              reg_big;
  logic [SH_W-1:0]   reg_low;
  logic [RAMT_W:0]   reg_ext;

  assign sign     = val[DATA_W-1];
  assign reg_ext  = {1'b0, reg_amt};
  assign reg_zero = (reg_amt == '0);
  assign reg_eq   = (reg_ext == FULL);
  assign reg_big  = (reg_ext >= FULL);
  assign reg_low  = reg_amt[SH_W-1:0];

  always_comb begin
    bar_amt     = '0;
    use_fixed   = 1'b0;
    fixed_val   = '0;
    fixed_carry = 1'b0;
    if (!from_reg) begin
      if (imm_amt == '0) begin
        use_fixed = 1'b1;
        case (kind)
          SK_LSL: begin fixed_val = val;               fixed_carry = carry_in; end
          SK_LSR: begin fixed_val = '0;                fixed_carry = sign;     end
          SK_ASR: begin fixed_val = {DATA_W{sign}};    fixed_carry = sign;     end
          default: begin
            fixed_val   = {carry_in, val[DATA_W-1:1]};
            fixed_carry = val[0];
          end
        endcase
      end else begin
        bar_amt = imm_amt;
      end
    end else if (reg_zero) begin
      use_fixed   = 1'b1;
      fixed_val   = val;
      fixed_carry = carry_in;
    end else begin
      case (kind)
        SK_LSL: begin
          if (reg_big) begin
            use_fixed   = 1'b1;
            fixed_carry = reg_eq & val[0];
          end else bar_amt = reg_low;
        end
        SK_LSR: begin
          if (reg_big) begin
            use_fixed   = 1'b1;
            fixed_carry = reg_eq & sign;
          end else bar_amt = reg_low;
        end
        SK_ASR: begin
          if (reg_big) begin
            use_fixed   = 1'b1;
            fixed_val   = {DATA_W{sign}};
            fixed_carry = sign;
          end else bar_amt = reg_low;
        end
        default: begin
          if (reg_low == '0) begin
            use_fixed   = 1'b1;
            fixed_val   = val;
            fixed_carry = sign;
          end else bar_amt = reg_low;
        end
      endcase
    end
  end
endmodule

// File: rtl/opsh_rotimm.sv
`timescale 1ns/1ps
// Prepares the barrel inputs for the rotated-constant mode.
module opsh_rotimm #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic [IMM_W-1:0]   imm_byte,
  input  logic [ROT_W-1:0]   imm_rot,
  output logic [DATA_W-1:0]  bar_val,
  output logic [SH_W-1:0]    bar_amt,
  output logic               rot_zero
);
  generate
    if (IMM_W < DATA_W) begin : g_ext
      assign bar_val = {{(DATA_W-IMM_W){1'b0}}, imm_byte};
    end else begin : g_full
      assign bar_val = imm_byte[DATA_W-1:0];
    end
  endgenerate

  assign bar_amt  = SH_W'({imm_rot, 1'b0});
  assign rot_zero = (imm_rot == '0);
endmodule

// File: rtl/opshift_unit.sv
`timescale 1ns/1ps
module opshift_unit
  import opsh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RAMT_W = 8,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  src_operand,
  input  logic [1:0]         shift_kind,
  input  logic               amt_from_reg,
  input  logic [SH_W-1:0]    imm_amount,
  input  logic [RAMT_W-1:0]  reg_amount,
  input  logic               carry_in,
  input  logic               rot_imm_mode,
  input  logic [IMM_W-1:0]   imm_byte,
  input  logic [ROT_W-1:0]   imm_rot,
  output logic               out_valid,
  output logic [DATA_W-1:0]  out_value,
  output logic               out_carry
);
  shift_kind_e        kind;
  logic [SH_W-1:0]    dec_amt;
  logic               use_fixed;
  logic [DATA_W-1:0]  fixed_val;
  logic               fixed_carry;
  logic [DATA_W-1:0]  ri_val;
  logic [SH_W-1:0]    ri_amt;
  logic               ri_zero;
  shift_kind_e        bar_kind;
  logic [DATA_W-1:0]  bar_val;
  logic [SH_W-1:0]    bar_amt;
  logic [DATA_W-1:0]  bar_res;
  logic               bar_cout;
  logic [DATA_W-1:0]  nxt_value;
  logic               nxt_carry;

  assign kind = shift_kind_e'(shift_kind);

  opsh_amount_decode #(.DATA_W(DATA_W), .RAMT_W(RAMT_W)) dec_i (
    .kind        (kind),
    .from_reg    (amt_from_reg),
    .imm_amt     (imm_amount),
    .reg_amt     (reg_amount),
    .val         (src_operand),
    .carry_in    (carry_in),
    .bar_amt     (dec_amt),
    .use_fixed   (use_fixed),
    .fixed_val   (fixed_val),
    .fixed_carry (fixed_carry)
  );

  opsh_rotimm #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) rot_i (
    .imm_byte (imm_byte),
    .imm_rot  (imm_rot),
    .bar_val  (ri_val),
    .bar_amt  (ri_amt),
    .rot_zero (ri_zero)
  );

  // One barrel serves both the operand shift and the constant rotation.
  assign bar_kind = rot_imm_mode ? SK_ROR : kind;
  assign bar_val  = rot_imm_mode ? ri_val : src_operand;
  assign bar_amt  = rot_imm_mode ? ri_amt : dec_amt;

  opsh_barrel #(.DATA_W(DATA_W)) bar_i (
    .kind (bar_kind),
    .val  (bar_val),
    .amt  (bar_amt),
    .res  (bar_res),
    .cout (bar_cout)
  );

  always_comb begin
    if (rot_imm_mode) begin
      nxt_value = bar_res;
      nxt_carry = ri_zero ? carry_in : bar_cout;
    end else if (use_fixed) begin
      nxt_value = fixed_val;
      nxt_carry = fixed_carry;
    end else begin
      nxt_value = bar_res;
      nxt_carry = bar_cout;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_value <= '0;
      out_carry <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_value <= nxt_value;
        out_carry <= nxt_carry;
      end
    end
  end
endmodule

// File: rtl/opshift_unit_checker.sv
`timescale 1ns/1ps
module opshift_unit_checker #(
  parameter int DATA_W = 32,
  parameter int RAMT_W = 8,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4,
  localparam int SH_W = $clog2(DATA_W)
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [DATA_W-1:0]  src_operand,
  input logic [1:0]         shift_kind,
  input logic               amt_from_reg,
  input logic [SH_W-1:0]    imm_amount,
  input logic [RAMT_W-1:0]  reg_amount,
  input logic               carry_in,
  input logic               rot_imm_mode,
  input logic [IMM_W-1:0]   imm_byte,
  input logic [ROT_W-1:0]   imm_rot,
  input logic               out_valid,
  input logic [DATA_W-1:0]  out_value,
  input logic               out_carry
);
  localparam logic [RAMT_W:0] FULL = (RAMT_W+1)'(DATA_W);

  logic shift_op;
  logic imm_zero;
  logic reg_over;
  logic reg_atleast;

  assign shift_op    = in_valid && !rot_imm_mode;
  assign imm_zero    = shift_op && !amt_from_reg && (imm_amount == '0);
  assign reg_over    = ({1'b0, reg_amount} > FULL);
  assign reg_atleast = ({1'b0, reg_amount} >= FULL);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_value) && $stable(out_carry)));

  assert_lsl_zero_pass_R3: assert property (@(posedge clk) disable iff (rst)
    (imm_zero && shift_kind == 2'd0) |=>
      (out_value == $past(src_operand) && out_carry == $past(carry_in)));

  assert_lsr_zero_full_R4: assert property (@(posedge clk) disable iff (rst)
    (imm_zero && shift_kind == 2'd1) |=>
      (out_value == '0 && out_carry == $past(src_operand[DATA_W-1])));

  assert_ror_zero_rrx_R5: assert property (@(posedge clk) disable iff (rst)
    (imm_zero && shift_kind == 2'd3) |=>
      (out_value == {$past(carry_in), $past(src_operand[DATA_W-1:1])} &&
       out_carry == $past(src_operand[0])));

  assert_reg_zero_pass_R6: assert property (@(posedge clk) disable iff (rst)
    (shift_op && amt_from_reg && reg_amount == '0) |=>
      (out_value == $past(src_operand) && out_carry == $past(carry_in)));

  assert_reg_over_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (shift_op && amt_from_reg && reg_over && shift_kind[1] == 1'b0) |=>
      (out_value == '0 && out_carry == 1'b0));

  assert_reg_asr_fill_R8: assert property (@(posedge clk) disable iff (rst)
    (shift_op && amt_from_reg && reg_atleast && shift_kind == 2'd2) |=>
      (out_value == {DATA_W{$past(src_operand[DATA_W-1])}} &&
       out_carry == $past(src_operand[DATA_W-1])));

  assert_rotimm_plain_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rot_imm_mode && imm_rot == '0) |=>
      (out_value == DATA_W'($past(imm_byte)) && out_carry == $past(carry_in)));
endmodule

bind opshift_unit opshift_unit_checker #(
  .DATA_W(DATA_W), .RAMT_W(RAMT_W), .IMM_W(IMM_W), .ROT_W(ROT_W)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .src_operand  (src_operand),
  .shift_kind   (shift_kind),
  .amt_from_reg (amt_from_reg),
  .imm_amount   (imm_amount),
  .reg_amount   (reg_amount),
  .carry_in     (carry_in),
  .rot_imm_mode (rot_imm_mode),
  .imm_byte     (imm_byte),
  .imm_rot      (imm_rot),
  .out_valid    (out_valid),
  .out_value    (out_value),
  .out_carry    (out_carry)
);

// File: tb/opshift_unit_tb_top.sv
`timescale 1ns/1ps
module opshift_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] src_operand = '0;
  logic [1:0]  shift_kind = '0;
  logic        amt_from_reg = 1'b0;
  logic [4:0]  imm_amount = '0;
  logic [7:0]  reg_amount = '0;
  logic        carry_in = 1'b0;
  logic        rot_imm_mode = 1'b0;
  logic [7:0]  imm_byte = '0;
  logic [3:0]  imm_rot = '0;
  logic        out_valid;
  logic [31:0] out_value;
  logic        out_carry;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  opshift_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_operand(src_operand),
    .shift_kind(shift_kind), .amt_from_reg(amt_from_reg),
    .imm_amount(imm_amount), .reg_amount(reg_amount), .carry_in(carry_in),
    .rot_imm_mode(rot_imm_mode), .imm_byte(imm_byte), .imm_rot(imm_rot),
    .out_valid(out_valid), .out_value(out_value), .out_carry(out_carry)
  );

  // Behavioural model: one bit position per step, written from the requirements.
  function automatic logic [32:0] model(input logic rm, input logic fr,
      input logic [1:0] k, input logic [4:0] ia, input logic [7:0] ra,
      input logic c, input logic [31:0] v, input logic [7:0] b,
      input logic [3:0] r);
    logic [31:0] x;
    logic cy;
    int n;
    if (rm) begin
      x = {24'h0, b};
      for (int i = 0; i < 2*r; i++) x = {x[0], x[31:1]};
      cy = (r == 0) ? c : x[31];
      return {cy, x};
    end
    x = v; cy = c;
    if (!fr && ia == 0) begin
      if (k == 2'd3) return {v[0], c, v[31:1]};
      n = (k == 2'd0) ? 0 : 32;
    end else begin
      n = fr ? int'(ra) : int'(ia);
    end
    for (int i = 0; i < n; i++) begin
      case (k)
        2'd0: begin cy = x[31]; x = {x[30:0], 1'b0}; end
        2'd1: begin cy = x[0];  x = {1'b0, x[31:1]}; end
        2'd2: begin cy = x[0];  x = {x[31], x[31:1]}; end
        default: begin x = {x[0], x[31:1]}; cy = x[31]; end
      endcase
    end
    return {cy, x};
  endfunction

  task automatic check(input string tag, input logic [31:0] av, input logic ac,
                       input logic avl, input logic [31:0] ev, input logic ec,
                       input logic evl);
    checks++;
    if (av !== ev || ac !== ec || avl !== evl) begin
      fails++;
      $display("FAIL %s: actual value=%h carry=%b valid=%b expected value=%h carry=%b valid=%b",
               tag, av, ac, avl, ev, ec, evl);
    end
  endtask

  task automatic run_op(input string tag, input logic rm, input logic fr,
      input logic [1:0] k, input logic [4:0] ia, input logic [7:0] ra,
      input logic c, input logic [31:0] v, input logic [7:0] b,
      input logic [3:0] r);
    logic [32:0] e;
    @(negedge clk);
    rot_imm_mode = rm; amt_from_reg = fr; shift_kind = k; imm_amount = ia;
    reg_amount = ra; carry_in = c; src_operand = v; imm_byte = b; imm_rot = r;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    e = model(rm, fr, k, ia, ra, c, v, b, r);
    check(tag, out_value, out_carry, out_valid, e[31:0], e[32], 1'b1);
  endtask

  task automatic t_reset;
    // R12: cleared while reset is held
    repeat (3) @(negedge clk);
    check("R12 reset state", out_value, out_carry, out_valid, 32'h0, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_imm_sweep;
    logic [31:0] pats [3];
    pats[0] = 32'h8000_0001; pats[1] = 32'h4C3A_96E5; pats[2] = 32'h7FFF_FFFE;
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < 4; k++)
        for (int n = 1; n < 32; n++)
          run_op("R2 immediate shift 1..31", 1'b0, 1'b0, 2'(k), 5'(n), 8'h0,
                 1'(p), pats[p], 8'h0, 4'h0);
  endtask

  task automatic t_imm_zero;
    for (int c = 0; c < 2; c++) begin
      run_op("R3 LSL #0 pass", 1'b0, 1'b0, 2'd0, 5'd0, 8'h0, 1'(c), 32'h8123_4560, 8'h0, 4'h0);
      run_op("R4 LSR #0 as 32", 1'b0, 1'b0, 2'd1, 5'd0, 8'h0, 1'(c), 32'h8000_0000, 8'h0, 4'h0);
      run_op("R4 ASR #0 neg", 1'b0, 1'b0, 2'd2, 5'd0, 8'h0, 1'(c), 32'h9000_0001, 8'h0, 4'h0);
      run_op("R4 ASR #0 pos", 1'b0, 1'b0, 2'd2, 5'd0, 8'h0, 1'(c), 32'h7000_0001, 8'h0, 4'h0);
      run_op("R5 ROR #0 through carry", 1'b0, 1'b0, 2'd3, 5'd0, 8'h0, 1'(c), 32'h0000_0003, 8'h0, 4'h0);
      run_op("R5 ROR #0 bit0 clear", 1'b0, 1'b0, 2'd3, 5'd0, 8'h0, 1'(c), 32'hF000_0002, 8'h0, 4'h0);
    end
  endtask

  task automatic t_reg_zero;
    for (int k = 0; k < 4; k++) begin
      run_op("R6 register amount 0", 1'b0, 1'b1, 2'(k), 5'd7, 8'h00, 1'b1, 32'hC000_0001, 8'h0, 4'h0);
      run_op("R6 register amount 0 c0", 1'b0, 1'b1, 2'(k), 5'd3, 8'h00, 1'b0, 32'h8000_0001, 8'h0, 4'h0);
    end
  endtask

  task automatic t_reg_edges;
    logic [7:0] amts [6];
    amts[0] = 8'd31; amts[1] = 8'd32; amts[2] = 8'd33;
    amts[3] = 8'd64; amts[4] = 8'd255; amts[5] = 8'd1;
    for (int a = 0; a < 6; a++) begin
      run_op("R7 register LSL saturation", 1'b0, 1'b1, 2'd0, 5'd0, amts[a], 1'b1, 32'h8000_0001, 8'h0, 4'h0);
      run_op("R7 register LSR saturation", 1'b0, 1'b1, 2'd1, 5'd0, amts[a], 1'b1, 32'h8000_0001, 8'h0, 4'h0);
      run_op("R8 register ASR neg", 1'b0, 1'b1, 2'd2, 5'd0, amts[a], 1'b0, 32'h8000_0002, 8'h0, 4'h0);
      run_op("R8 register ASR pos", 1'b0, 1'b1, 2'd2, 5'd0, amts[a], 1'b1, 32'h4000_0001, 8'h0, 4'h0);
    end
  endtask

  task automatic t_reg_ror;
    logic [7:0] amts [6];
    amts[0] = 8'd32; amts[1] = 8'd64; amts[2] = 8'd224;
    amts[3] = 8'd33; amts[4] = 8'd40; amts[5] = 8'd255;
    for (int a = 0; a < 6; a++) begin
      run_op("R9 register ROR", 1'b0, 1'b1, 2'd3, 5'd0, amts[a], 1'b0, 32'h8765_4321, 8'h0, 4'h0);
      run_op("R9 register ROR low", 1'b0, 1'b1, 2'd3, 5'd0, amts[a], 1'b1, 32'h1234_5678, 8'h0, 4'h0);
    end
  endtask

  task automatic t_rotimm;
    logic [3:0] rots [4];
    rots[0] = 4'd0; rots[1] = 4'd1; rots[2] = 4'd4; rots[3] = 4'd15;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 2; c++) begin
        run_op("R10 rotated constant", 1'b1, 1'b0, 2'd0, 5'd0, 8'h0, 1'(c), 32'h0, 8'hA5, rots[r]);
        run_op("R10 rotated constant low", 1'b1, 1'b0, 2'd0, 5'd0, 8'h0, 1'(c), 32'h0, 8'h03, rots[r]);
      end
  endtask

  task automatic t_rotimm_priority;
    // R11: shift fields set to values that would change the result
    run_op("R11 shift fields ignored", 1'b1, 1'b1, 2'd2, 5'd9, 8'd40, 1'b1, 32'hFFFF_FFFF, 8'h81, 4'd2);
    run_op("R11 shift fields ignored imm", 1'b1, 1'b0, 2'd3, 5'd0, 8'd0, 1'b0, 32'hDEAD_BEEF, 8'h7E, 4'd0);
  endtask

  task automatic t_hold;
    logic [32:0] e;
    // R1: one-cycle latency, then hold while idle
    e = model(1'b0, 1'b0, 2'd1, 5'd4, 8'h0, 1'b0, 32'h1234_5678, 8'h0, 4'h0);
    run_op("R1 latency", 1'b0, 1'b0, 2'd1, 5'd4, 8'h0, 1'b0, 32'h1234_5678, 8'h0, 4'h0);
    src_operand = 32'hFFFF_0000; shift_kind = 2'd0; imm_amount = 5'd1; carry_in = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle hold", out_value, out_carry, out_valid, e[31:0], e[32], 1'b0);
  endtask

  initial begin
    t_reset();
    t_hold();
    t_imm_sweep();
    t_imm_zero();
    t_reg_zero();
    t_reg_edges();
    t_reg_ror();
    t_rotimm();
    t_rotimm_priority();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule